// File: doc/BRIEF.md
# Reconfigurable Two-Table Logic Slice

This block is one programmable logic cell built around a pair of 16-entry lookup tables. A 3-bit mode input sets how the same 32 storage bits are used. In dual-function mode each table is a separate 4-input function. In wide mode the two tables join into one 5-input function. In ROM mode they act as two independent 16x1 read-only memories. In RAM mode they act as one 16-word by 2-bit single-port memory, with a synchronous write and a combinational read.

The contents are loaded in a configuration mode, either as a whole 32-bit word in one cycle or one bit per cycle through a serial shift path. A parameter removes the RAM capability for a slice variant that lacks it. In that variant the RAM code reads as zero and writes nothing.

Top module: `lut_slice`

## Requirements
- R1: A synchronous reset clears all 32 table bits, so every read mode returns zero until the tables are loaded.
- R2: In configuration mode (mode code 4) with `cfg_load` high, the image is replaced at the clock edge by `cfg_word`. Bit i of `cfg_word` (0..15) becomes entry i of table 0, and bit 16+i becomes entry i of table 1.
- R3: In configuration mode with `cfg_shift` high and `cfg_load` low, the 32-bit image shifts one place toward bit 0 and `cfg_sin` enters bit 31. After 32 shifts, the first bit sent sits in bit 0. When both strobes are high, the parallel load wins.
- R4: In dual-function mode (code 0), `dout[0]` is table 0 at index `in_a` and `dout[1]` is table 1 at index `in_b`. Both are combinational.
- R5: In wide mode (code 1), both tables are indexed by `in_a`. `dout[0]` takes table 1 when `in_e` is high and table 0 when it is low, and `dout[1]` is 0.
- R6: In ROM mode (code 2), the reads are the same as in R4, and a high `ram_we` leaves the contents unchanged.
- R7: In RAM mode (code 3), both tables are addressed by `in_a`, and `dout` is {table 1, table 0} at that address, without a clock.
- R8: In RAM mode, `ram_we` high writes `ram_wd[0]` into table 0 and `ram_wd[1]` into table 1 at address `in_a` on the clock edge. The new word is visible in the next cycle.
- R9: The configuration strobes have no effect outside mode code 4, and `ram_we` has no effect outside mode code 3.
- R10: In configuration mode and for the unused codes 5 to 7, `dout` is 0. The unused codes also leave the contents unchanged.
- R11: With `HAS_RAM` = 0, mode code 3 returns zero on `dout` and its writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Mode code: 0 dual, 1 wide, 2 ROM, 3 RAM, 4 configuration |
| in_a | input | 4 | Index for table 0; shared index in wide and RAM modes |
| in_b | input | 4 | Index for table 1 in dual and ROM modes |
| in_e | input | 1 | Fifth input in wide mode (selects table 1 when high) |
| ram_we | input | 1 | RAM write enable |
| ram_wd | input | 2 | RAM write data, bit t goes to table t |
| cfg_load | input | 1 | Parallel load strobe |
| cfg_word | input | 32 | Parallel configuration image |
| cfg_shift | input | 1 | Serial shift strobe |
| cfg_sin | input | 1 | Serial configuration bit, enters at bit 31 |
| dout | output | 2 | Slice outputs |

## Verification
The bench sweeps every index in dual mode with a loaded image. A slice that swapped the table halves, or indexed table 1 with `in_a`, would give mismatches at most addresses. It drives wide mode with `in_e` at both levels, which catches an inverted select or a stray value on `dout[1]`. It sends a full serial stream and also asserts load and shift together, which catches a reversed shift direction and a wrong priority between the strobes. Writes are issued in ROM mode, configuration strobes are pulsed in the read modes, and the unused codes are exercised, with every table entry read back afterwards, so a leaking write enable changes a later read. A second instance built without RAM is driven alongside the first, so a variant that still stores or returns data in code 3 is caught.

// File: rtl/lutslice_pkg.sv
package lutslice_pkg;
    localparam int LUT_INPUTS = 4;
    localparam int LUT_DEPTH  = 1 << LUT_INPUTS;
    localparam int NUM_TABLES = 2;
    localparam int IMAGE_BITS = LUT_DEPTH * NUM_TABLES;
    localparam int MODE_W     = 3;

    typedef enum logic [MODE_W-1:0] {
        MD_DUAL = 3'd0,
        MD_WIDE = 3'd1,
        MD_ROM  = 3'd2,
        MD_RAM  = 3'd3,
        MD_CFG  = 3'd4
    } slice_mode_e;

    typedef struct packed {
        logic rd_dual;
        logic rd_wide;
        logic rd_ram;
        logic cfg_en;
        logic ram_en;
    } mode_flags_t;

    typedef struct packed {
        logic                  ld;
        logic                  sh;
        logic                  sin;
        logic [IMAGE_BITS-1:0] word;
    } cfg_req_t;

    typedef struct packed {
        logic                  we;
        logic [NUM_TABLES-1:0] wd;
        logic [LUT_INPUTS-1:0] addr;
    } ram_req_t;

    function automatic logic lut_pick(input logic [LUT_DEPTH-1:0] tbl,
                                      input logic [LUT_INPUTS-1:0] idx);
        return tbl[idx];
    endfunction
endpackage

// File: rtl/lutslice_decode.sv
module lutslice_decode
    import lutslice_pkg::*;
#(
    parameter bit HAS_RAM = 1'b1
) (
    input  logic [MODE_W-1:0] mode,
    output mode_flags_t       flags
);
    always_comb begin
        flags = '0;
        case (mode)
            MD_DUAL, MD_ROM: flags.rd_dual = 1'b1;
            MD_WIDE:         flags.rd_wide = 1'b1;
            MD_RAM: begin
                flags.rd_ram = HAS_RAM;
                flags.ram_en = HAS_RAM;
            end
            MD_CFG:          flags.cfg_en  = 1'b1;
            default:         flags = '0;
        endcase
    end
endmodule

// File: rtl/lutslice_store.sv
module lutslice_store
    import lutslice_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_en,
    input  cfg_req_t              cfg,
    input  logic                  ram_en,
    input  ram_req_t              ram,
    output logic [IMAGE_BITS-1:0] image
);
    always_ff @(posedge clk) begin
        if (rst) begin
            image <= '0;
        end else if (cfg_en && cfg.ld) begin
            image <= cfg.word;
        end else if (cfg_en && cfg.sh) begin
            image <= {cfg.sin, image[IMAGE_BITS-1:1]};
        end else if (ram_en && ram.we) begin
            for (int t = 0; t < NUM_TABLES; t++) begin
                image[t*LUT_DEPTH + int'(ram.addr)] <= ram.wd[t];
            end
        end
    end
endmodule

// File: rtl/lutslice_read.sv
module lutslice_read
    import lutslice_pkg::*;
(
    input  logic [LUT_DEPTH-1:0]  tbl,
    input  logic [LUT_INPUTS-1:0] own_idx,
    input  logic [LUT_INPUTS-1:0] shared_idx,
    input  logic                  use_shared,
    output logic                  bit_out
);
    logic [LUT_INPUTS-1:0] idx;

    always_comb begin
        idx     = use_shared ? shared_idx : own_idx;
        bit_out = lut_pick(tbl, idx);
    end
endmodule

// File: rtl/lut_slice.sv
module lut_slice
    import lutslice_pkg::*;
#(
    parameter bit HAS_RAM = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [MODE_W-1:0]     mode,
    input  logic [LUT_INPUTS-1:0] in_a,
    input  logic [LUT_INPUTS-1:0] in_b,
    input  logic                  in_e,
    input  logic                  ram_we,
    input  logic [NUM_TABLES-1:0] ram_wd,
    input  logic                  cfg_load,
    input  logic [IMAGE_BITS-1:0] cfg_word,
    input  logic                  cfg_shift,
    input  logic                  cfg_sin,
    output logic [NUM_TABLES-1:0] dout
);
    mode_flags_t                          flags;
    cfg_req_t                             cfg;
    ram_req_t                             ram;
    logic [IMAGE_BITS-1:0]                image;
    logic [NUM_TABLES-1:0]                rd;
    logic [NUM_TABLES-1:0][LUT_INPUTS-1:0] own_idx;

    assign cfg = '{ld: cfg_load, sh: cfg_shift, sin: cfg_sin, word: cfg_word};
    assign ram = '{we: ram_we, wd: ram_wd, addr: in_a};
    assign own_idx[0] = in_a;
    assign own_idx[1] = in_b;

    lutslice_decode #(.HAS_RAM(HAS_RAM)) u_decode (
        .mode  (mode),
        .flags (flags)
    );

    lutslice_store u_store (
        .clk    (clk),
        .rst    (rst),
        .cfg_en (flags.cfg_en),
        .cfg    (cfg),
        .ram_en (flags.ram_en),
        .ram    (ram),
        .image  (image)
    );

    for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tbl
        lutslice_read u_read (
            .tbl        (image[t*LUT_DEPTH +: LUT_DEPTH]),
            .own_idx    (own_idx[t]),
            .shared_idx (in_a),
            .use_shared (flags.rd_wide | flags.rd_ram),
            .bit_out    (rd[t])
        );
    end

    always_comb begin
        dout = '0;
        if (flags.rd_ram || flags.rd_dual) begin
            dout = rd;
        end else if (flags.rd_wide) begin
            dout[0] = in_e ? rd[1] : rd[0];
        end
    end
endmodule

// File: rtl/lut_slice_chk.sv
module lut_slice_chk
    import lutslice_pkg::*;
#(
    parameter bit HAS_RAM = 1'b1
) (
    input logic                  clk,
    input logic                  rst,
    input logic [MODE_W-1:0]     mode,
    input logic [LUT_INPUTS-1:0] in_a,
    input logic                  ram_we,
    input logic [NUM_TABLES-1:0] ram_wd,
    input logic                  cfg_load,
    input logic [IMAGE_BITS-1:0] cfg_word,
    input logic                  cfg_shift,
    input logic                  cfg_sin,
    input logic [NUM_TABLES-1:0] dout,
    input logic [IMAGE_BITS-1:0] image
);
    p_parallel_load_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd4 && cfg_load) |=> image == $past(cfg_word));

    p_serial_shift_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd4 && !cfg_load && cfg_shift)
            |=> image == {$past(cfg_sin), $past(image[IMAGE_BITS-1:1])});

    p_wide_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd1) |-> dout[1] == 1'b0);

    p_ram_write_r8: assert property (@(posedge clk) disable iff (rst)
        (HAS_RAM && mode == 3'd3 && ram_we)
            |=> (image[$past(in_a)] == $past(ram_wd[0]))
             && (image[LUT_DEPTH + int'($past(in_a))] == $past(ram_wd[1])));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!(mode == 3'd4 && (cfg_load || cfg_shift))
         && !(HAS_RAM && mode == 3'd3 && ram_we)) |=> $stable(image));

    p_quiet_codes_r10: assert property (@(posedge clk) disable iff (rst)
        (mode >= 3'd4) |-> dout == '0);

    p_noram_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (!HAS_RAM && mode == 3'd3) |-> dout == '0);
endmodule

bind lut_slice lut_slice_chk #(.HAS_RAM(HAS_RAM)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .in_a      (in_a),
    .ram_we    (ram_we),
    .ram_wd    (ram_wd),
    .cfg_load  (cfg_load),
    .cfg_word  (cfg_word),
    .cfg_shift (cfg_shift),
    .cfg_sin   (cfg_sin),
    .dout      (dout),
    .image     (image)
);

// File: tb/lut_slice_test.sv
`timescale 1ns/1ps
module lut_slice_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode = '0;
    logic [3:0]  in_a = '0, in_b = '0;
    logic        in_e = 1'b0, ram_we = 1'b0;
    logic [1:0]  ram_wd = '0;
    logic        cfg_load = 1'b0, cfg_shift = 1'b0, cfg_sin = 1'b0;
    logic [31:0] cfg_word = '0;
    logic [1:0]  dout, dout_nr;

    int checks = 0, failures = 0;
    bit done = 0;

    logic [1:0]  q_exp[$];
    logic [1:0]  q_exp_nr[$];
    string       q_tag[$];
    string       q_tag_nr[$];
    logic [31:0] mdl = '0, mdl_nr = '0;

    always #4 clk = ~clk;

    lut_slice #(.HAS_RAM(1'b1)) uut (
        .clk(clk), .rst(rst), .mode(mode), .in_a(in_a), .in_b(in_b), .in_e(in_e),
        .ram_we(ram_we), .ram_wd(ram_wd), .cfg_load(cfg_load), .cfg_word(cfg_word),
        .cfg_shift(cfg_shift), .cfg_sin(cfg_sin), .dout(dout));

    lut_slice #(.HAS_RAM(1'b0)) uut_nr (
        .clk(clk), .rst(rst), .mode(mode), .in_a(in_a), .in_b(in_b), .in_e(in_e),
        .ram_we(ram_we), .ram_wd(ram_wd), .cfg_load(cfg_load), .cfg_word(cfg_word),
        .cfg_shift(cfg_shift), .cfg_sin(cfg_sin), .dout(dout_nr));

    function automatic logic [1:0] model_out(input logic [2:0] m, input logic [31:0] t,
            input logic [3:0] a, input logic [3:0] b, input logic e, input bit ram_ok);
        case (m)
            3'd0, 3'd2: return {t[16 + int'(b)], t[a]};
            3'd1:       return {1'b0, e ? t[16 + int'(a)] : t[a]};
            3'd3:       return ram_ok ? {t[16 + int'(a)], t[a]} : 2'b00;
            default:    return 2'b00;
        endcase
    endfunction

    function automatic logic [31:0] model_next(input logic [31:0] t, input bit ram_ok);
        logic [31:0] n = t;
        if (mode == 3'd4 && cfg_load)       n = cfg_word;
        else if (mode == 3'd4 && cfg_shift) n = {cfg_sin, t[31:1]};
        else if (mode == 3'd3 && ram_we && ram_ok) begin
            n[in_a] = ram_wd[0];
            n[16 + int'(in_a)] = ram_wd[1];
        end
        return n;
    endfunction

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // driver: apply one cycle of stimulus, queue the expected outputs
    task automatic step(input logic [2:0] m, input logic [3:0] a, input logic [3:0] b,
            input logic e, input logic we, input logic [1:0] wd, input logic ld,
            input logic [31:0] word, input logic sh, input logic sin, input string tag);
        @(negedge clk);
        mode = m; in_a = a; in_b = b; in_e = e; ram_we = we; ram_wd = wd;
        cfg_load = ld; cfg_word = word; cfg_shift = sh; cfg_sin = sin;
        q_exp.push_back(model_out(m, mdl, a, b, e, 1'b1));
        q_exp_nr.push_back(model_out(m, mdl_nr, a, b, e, 1'b0));
        q_tag.push_back(tag);
        q_tag_nr.push_back(m == 3'd3 ? "R11" : tag);
        mdl    = model_next(mdl, 1'b1);
        mdl_nr = model_next(mdl_nr, 1'b0);
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < 16; i++)
            step(3'd0, 4'(i), 4'(15 - i), 1'b0, 1'b0, 2'b00, 1'b0, '0, 1'b0, 1'b0, tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (q_exp.size() > 0) begin
                check(q_tag.pop_front(), dout, q_exp.pop_front());
                check(q_tag_nr.pop_front(), dout_nr, q_exp_nr.pop_front());
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] ser;
        ser = 32'h1F2E_3D4C;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: cleared after reset
        step(3'd0, 4'd5, 4'd9, 1'b0, 1'b0, 2'b00, 1'b0, '0, 1'b0, 1'b0, "R1");
        step(3'd3, 4'd7, 4'd0, 1'b0, 1'b0, 2'b00, 1'b0, '0, 1'b0, 1'b0, "R1");
        // R2 parallel load, R10 config output zero
        step(3'd4, 4'd1, 4'd2, 1'b0, 1'b0, 2'b00, 1'b1, 32'hA5C3_96F0, 1'b0, 1'b0, "R10");
        read_all("R2_R4");
        // R5 wide mode
        for (int i = 0; i < 16; i++) begin
            step(3'd1, 4'(i), 4'd0, 1'b0, 1'b0, 2'b00, 1'b0, '0, 1'b0, 1'b0, "R5");
            step(3'd1, 4'(i), 4'd3, 1'b1, 1'b0, 2'b00, 1'b0, '0, 1'b0, 1'b0, "R5");
        end
        // R6 ROM reads, write ignored
        for (int i = 0; i < 16; i += 3)
            step(3'd2, 4'(i), 4'(i + 1), 1'b0, 1'b1, ~mdl[i +: 2], 1'b0, '0, 1'b0, 1'b0, "R6");
        read_all("R6");
        // R9 config strobes in read modes, RAM write in wide mode
        step(3'd0, 4'd2, 4'd6, 1'b0, 1'b0, 2'b00, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b1, "R9");
        step(3'd1, 4'd4, 4'd0, 1'b1, 1'b1, 2'b11, 1'b0, '0, 1'b1, 1'b0, "R9");
        step(3'd3, 4'd8, 4'd0, 1'b0, 1'b0, 2'b00, 1'b1, 32'h0, 1'b1, 1'b0, "R9");
        read_all("R9");
        // R10 unused codes
        for (int m = 5; m < 8; m++)
            step(3'(m), 4'd9, 4'd1, 1'b1, 1'b1, 2'b11, 1'b1, 32'h0, 1'b1, 1'b1, "R10");
        read_all("R10");
        // R3 serial stream, first bit ends at bit 0
        for (int i = 0; i < 32; i++)
            step(3'd4, 4'd0, 4'd0, 1'b0, 1'b0, 2'b00, 1'b0, '0, 1'b1, ser[i], "R3");
        read_all("R3");
        // R3 load wins over shift
        step(3'd4, 4'd0, 4'd0, 1'b0, 1'b0, 2'b00, 1'b1, 32'h5A0F_C3E1, 1'b1, 1'b1, "R3");
        read_all("R3");
        // R7 RAM reads, R8 RAM writes
        for (int i = 0; i < 16; i += 5)
            step(3'd3, 4'(i), 4'd0, 1'b0, 1'b0, 2'b00, 1'b0, '0, 1'b0, 1'b0, "R7");
        for (int i = 0; i < 16; i++) begin
            step(3'd3, 4'(i), 4'd0, 1'b0, 1'b1, 2'(i + 1), 1'b0, '0, 1'b0, 1'b0, "R8");
            step(3'd3, 4'(i), 4'd0, 1'b0, 1'b0, 2'b00, 1'b0, '0, 1'b0, 1'b0, "R8");
        end
        read_all("R8");
        read_all("R11");
        repeat (3) @(negedge clk);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule